// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block lets the two processors on either side of a shared dual-port memory interrupt each other. The top two words of the address space serve as mailboxes, and each side owns one of them. When a port writes the other side's mailbox, the owning side's interrupt flag is raised. The owner clears the flag by reading its own mailbox. The mailbox words stay ordinary storage locations in the external memory array, which holds the full-width message. This block does not touch data. It only watches the command signals of both ports.

The block samples each port's select, write, output-enable and address once per clock. It also takes a busy indication for each port from the external arbitration logic. It drives one registered, active-low interrupt output per side. A parameter can remove the mailbox side effects, so that the top two addresses behave as plain memory.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is active, and after it is released, both `l_irq_n` and `r_irq_n` are high (deasserted). Reset assertion takes effect at once. Release takes effect after a two-flop synchroniser.
- R2: The right-side access `r_sel=1`, `r_wr=1` to address all-ones-minus-one drives `l_irq_n` low on the clock after the sampled access.
- R3: The left-side access `l_sel=1`, `l_oe=1` to address all-ones-minus-one drives `l_irq_n` high on the next clock. The value of `l_wr` does not matter for this access.
- R4: The left-side access `l_sel=1`, `l_wr=1` to the all-ones address drives `r_irq_n` low on the next clock.
- R5: The right-side access `r_sel=1`, `r_oe=1` to the all-ones address drives `r_irq_n` high on the next clock, whatever `r_wr` is.
- R6: A set or clear access leaves the flag unchanged when the busy input of the port making that access is high.
- R7: When a set and a clear of the same flag are sampled in the same cycle, the flag ends up asserted.
- R8: The following accesses have no effect on either flag: any access to other addresses, a port writing its own mailbox, a port reading the other side's mailbox, and any access with select low.
- R9: With `MBX_EN=0`, both interrupt outputs stay high for every access pattern.
- R10: A flag holds its value in every cycle that has no effective set or clear for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left port selected (active high) |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port output enable (active high) |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port busy from arbitration (active high) |
| r_sel | input | 1 | Right port selected (active high) |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port output enable (active high) |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port busy from arbitration (active high) |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with `ADDR_W=3`, which leaves eight addresses per port. At that size, every pair of left and right addresses can be combined with all 256 patterns of the eight control and busy inputs in about 16k cycles. That sweep reaches every cross-port set, own-port clear, busy block and same-cycle collision, starting from the flag states that the earlier steps leave behind. A second instance with `MBX_EN=0` receives the same stimulus, to show that the top addresses have no side effects in that build.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  // Command sampled from one port in one cycle
  typedef struct packed {
    logic sel;
    logic wr;
    logic oe;
    logic busy;
  } mbx_cmd_t;

  // Effective mailbox events produced by one port
  typedef struct packed {
    logic wr_hi;   // write to all-ones address
    logic wr_lo;   // write to all-ones minus one
    logic rd_hi;   // read access to all-ones address
    logic rd_lo;   // read access to all-ones minus one
  } mbx_evt_t;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter bit          MBX_EN = 1'b1
) (
  input  mbx_cmd_t          cmd,
  input  logic [ADDR_W-1:0] addr,
  output mbx_evt_t          evt
);
  localparam logic [ADDR_W-1:0] ADDR_HI = '1;
  localparam logic [ADDR_W-1:0] ADDR_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

  generate
    if (MBX_EN) begin : g_on
      logic live, hit_hi, hit_lo, do_wr, do_rd;
      always_comb begin
        live   = cmd.sel & ~cmd.busy;
        hit_hi = (addr == ADDR_HI);
        hit_lo = (addr == ADDR_LO);
        do_wr  = live & cmd.wr;
        do_rd  = live & cmd.oe;
        evt.wr_hi = do_wr & hit_hi;
        evt.wr_lo = do_wr & hit_lo;
        evt.rd_hi = do_rd & hit_hi;
        evt.rd_lo = do_rd & hit_lo;
      end
    end else begin : g_off
      assign evt = '0;
    end
  endgenerate
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_q_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;            // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq_n = ~flag_q;
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter bit          MBX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  logic                    rst_q_n;
  mbx_cmd_t                cmd  [NUM_PORTS];
  logic [ADDR_W-1:0]       addr [NUM_PORTS];
  mbx_evt_t                evt  [NUM_PORTS];

  always_comb begin
    cmd[PORT_L]  = '{sel: l_sel, wr: l_wr, oe: l_oe, busy: l_busy};
    cmd[PORT_R]  = '{sel: r_sel, wr: r_wr, oe: r_oe, busy: r_busy};
    addr[PORT_L] = l_addr;
    addr[PORT_R] = r_addr;
  end

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      mbx_port_decode #(.ADDR_W(ADDR_W), .MBX_EN(MBX_EN)) u_dec (
        .cmd (cmd[p]),
        .addr(addr[p]),
        .evt (evt[p])
      );
    end
  endgenerate

  // Left flag: raised by right writing all-ones-minus-one, cleared by left reading it
  mbx_flag u_flag_l (
    .clk    (clk),
    .rst_q_n(rst_q_n),
    .set_i  (evt[PORT_R].wr_lo),
    .clr_i  (evt[PORT_L].rd_lo),
    .irq_n  (l_irq_n)
  );

  // Right flag: raised by left writing all-ones, cleared by right reading it
  mbx_flag u_flag_r (
    .clk    (clk),
    .rst_q_n(rst_q_n),
    .set_i  (evt[PORT_L].wr_hi),
    .clr_i  (evt[PORT_R].rd_hi),
    .irq_n  (r_irq_n)
  );
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter bit          MBX_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q_n,
  input logic              l_sel,
  input logic              l_wr,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy,
  input logic              r_sel,
  input logic              r_wr,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] A_HI = '1;
  localparam logic [ADDR_W-1:0] A_LO = A_HI - 1'b1;

  logic l_set, l_clr, r_set, r_clr;
  assign l_set = MBX_EN && r_sel && r_wr && !r_busy && (r_addr == A_LO);
  assign l_clr = MBX_EN && l_sel && l_oe && !l_busy && (l_addr == A_LO);
  assign r_set = MBX_EN && l_sel && l_wr && !l_busy && (l_addr == A_HI);
  assign r_clr = MBX_EN && r_sel && r_oe && !r_busy && (r_addr == A_HI);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_q_n |=> (l_irq_n && r_irq_n));
  // R2
  l_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n) l_set |=> !l_irq_n);
  // R3
  l_clr_chk: assert property (@(posedge clk) disable iff (!rst_q_n) (l_clr && !l_set) |=> l_irq_n);
  // R4
  r_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n) r_set |=> !r_irq_n);
  // R5
  r_clr_chk: assert property (@(posedge clk) disable iff (!rst_q_n) (r_clr && !r_set) |=> r_irq_n);
  // R10
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n) (!l_set && !l_clr) |=> $stable(l_irq_n));
  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n) (!r_set && !r_clr) |=> $stable(r_irq_n));
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !MBX_EN |-> (l_irq_n && r_irq_n));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W), .MBX_EN(MBX_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n),
  .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
  .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb_top;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] HI = 3'd7;
  localparam logic [AW-1:0] LO = 3'd6;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sel, l_wr, l_oe, l_busy, r_sel, r_wr, r_oe, r_busy;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n, l_irq_off_n, r_irq_off_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit m_l = 0, m_r = 0;   // model flags, 1 = asserted

  always #2 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW), .MBX_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n));

  mbx_irq_ctrl #(.ADDR_W(AW), .MBX_EN(1'b0)) dut_off_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_off_n), .r_irq_n(r_irq_off_n));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic [AW-1:0] la, input logic [AW-1:0] ra);
    {l_sel, l_wr, l_oe, l_busy, r_sel, r_wr, r_oe, r_busy} = c;
    l_addr = la;
    r_addr = ra;
  endtask

  // one cycle: apply at negedge, compute expected, check at next negedge
  task automatic step(input logic [7:0] c, input logic [AW-1:0] la, input logic [AW-1:0] ra);
    bit ls, lc, rs, rc;
    string lt, rt;
    apply(c, la, ra);
    ls = r_sel && r_wr && !r_busy && (r_addr == LO);
    lc = l_sel && l_oe && !l_busy && (l_addr == LO);
    rs = l_sel && l_wr && !l_busy && (l_addr == HI);
    rc = r_sel && r_oe && !r_busy && (r_addr == HI);
    lt = (ls && lc) ? "R7" : ls ? "R2" : lc ? "R3" :
         ((r_sel && r_wr && r_addr == LO) || (l_sel && l_oe && l_addr == LO)) ? "R6" :
         (l_addr == LO || r_addr == LO) ? "R8" : "R10";
    rt = (rs && rc) ? "R7" : rs ? "R4" : rc ? "R5" :
         ((l_sel && l_wr && l_addr == HI) || (r_sel && r_oe && r_addr == HI)) ? "R6" :
         (l_addr == HI || r_addr == HI) ? "R8" : "R10";
    if (ls) m_l = 1; else if (lc) m_l = 0;
    if (rs) m_r = 1; else if (rc) m_r = 0;
    @(negedge clk);
    check(lt, l_irq_n, ~m_l);
    check(rt, r_irq_n, ~m_r);
    check("R9", l_irq_off_n & r_irq_off_n, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    apply(8'h00, '0, '0);
    repeat (3) @(negedge clk);
    check("R1", l_irq_n & r_irq_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", l_irq_n & r_irq_n, 1'b1);

    // directed: R2 set, then R3 clear with l_wr high
    step(8'b0000_1100, 3'd0, LO);            // right writes LO
    step(8'b1110_0000, LO, 3'd0);            // left sel+wr+oe at LO clears (R3)
    // directed R4 then R7 collision on right flag
    step(8'b1100_0000, HI, 3'd0);            // R4
    step(8'b1100_1010, HI, HI);              // R7: set and clear together
    // directed R8: left writes its own mailbox, right reads left's mailbox
    step(8'b1100_1010, LO, LO);
    // directed R6: busy blocks right's clear
    step(8'b0000_1011, 3'd0, HI);
    step(8'b0000_1010, 3'd0, HI);            // R5 clear

    // near-exhaustive sweep over addresses and control patterns
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v = 14'(i);
      step(v[13:6], v[2:0], v[5:3]);
    end

    // R1: asynchronous reset with a flag set
    step(8'b1100_0000, HI, 3'd0);
    #1 rst_n = 1'b0;
    #1 check("R1", l_irq_n & r_irq_n, 1'b1);
    m_l = 0; m_r = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule